// File: doc/BRIEF.md
# Boundary run-test pattern engine

This block runs the built-in self-test operations on the boundary cells of an 18-bit bidirectional transceiver. On each rising test-clock edge, while the test controller sits in Run-Test/Idle under a run-test instruction, it advances two groups of 18 cells. The output cells feed the driven pins. The input cells hold what the active direction's input pins deliver. A 3-bit opcode selects what the cells do. They can toggle, run as pseudo-random generators, compress input pins into a signature, or do a split mix of these. In the split modes the input half compresses while the output half generates a pattern or counts.

Each step runs only when both bytes of the transceiver point the same single way. If the direction enables disagree, the block acts as a bypass and leaves every cell alone. Masked input pins are forced to zero before they reach the signature. A shadow stage copies the output cells on the falling test-clock edge. That copy is the value driven onto the pins.

Top module: `rt_pattern_engine`

## Requirements
- R1: While rst_ni is low, out_cells_o is 18'h2AAAA, in_cells_o is 18'h00001 and drv_o is 0.
- R2: A step happens on a rising edge only when run_i is 1 and the directions are consistent. Consistent means oe_ab_i[b] differs from oe_ba_i[b] for both bytes b, and oe_ab_i[0] equals oe_ab_i[1]. Otherwise both cell groups keep their values.
- R3: With op_i[1:0]=00, each step inverts every output cell. The input cells keep their values whatever pin_i carries.
- R4: On the falling edge after a rising edge, if run_i is 1 and the directions are consistent, drv_o takes the value of out_cells_o. Otherwise drv_o holds.
- R5: With op_i[1:0]=01, the 36-bit state S={out_cells_o,in_cells_o} steps to {S[34:0], S[35]^S[24]}.
- R6: With op_i[1:0]=10, S steps to {S[34:0], S[35]^S[24]} XOR {18'b0, d}, where d = pin_i & ~mask_i.
- R7: With op_i=011, the input cells I step to {I[16:0], I[17]^I[10]} XOR d. At the same time the output cells O step to {O[16:0], O[17]^O[10]}.
- R8: With op_i=111, the input cells step as in R7, and the output cells step to O+1 modulo 2^18.
- R9: mask_i[k]=1 removes pin_i[k] (pin k+1 of the active direction) from every signature. mask_i[k]=0 includes it.
- R10: out_en_o[b] = oe_ab_i[b] XOR oe_ba_i[b], whatever op_i and run_i are.
- R11: op_i[2] is ignored unless op_i[1:0]=11. Codes 100, 101 and 110 act exactly as 000, 001 and 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run-Test/Idle with run-test instruction active |
| op_i | input | 3 | Test operation opcode |
| mask_i | input | 18 | Per-pin signature mask, 1 excludes |
| oe_ab_i | input | 2 | Per-byte A-to-B direction enable |
| oe_ba_i | input | 2 | Per-byte B-to-A direction enable |
| pin_i | input | 18 | Input pins of the active direction |
| out_en_o | output | 2 | Per-byte output drive enable |
| out_cells_o | output | 18 | Output cell shift stages |
| in_cells_o | output | 18 | Input cell stages |
| drv_o | output | 18 | Shadow value driven on the output pins |

## Verification
The hardest case to reach from the ports is a mask that really drops a pin from the signature. An unmasked pin at zero gives the same signature as a masked pin, so a plain run cannot tell them apart. The stimulus therefore drives all pins high while sweeping several masks in the compressing modes. Each signature is compared step by step against an independent model. Mixed-direction settings are also applied in the middle of an active pattern, so that a bypass which moves any cell shows up at once.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [2:0] {
    M_TOGGLE   = 3'd0,
    M_PRPG36   = 3'd1,
    M_PSA36    = 3'd2,
    M_PSA_PRPG = 3'd3,
    M_PSA_CNT  = 3'd4
  } mode_e;
endpackage

// File: rtl/rt_mode_decode.sv
module rt_mode_decode #(
  parameter int NBYTES = 2
) (
  input  logic              run_i,
  input  logic [2:0]        op_i,
  input  logic [NBYTES-1:0] oe_ab_i,
  input  logic [NBYTES-1:0] oe_ba_i,
  output rt_pkg::mode_e     mode_o,
  output logic              adv_o
);
  import rt_pkg::*;

  logic valid;

  always_comb begin
    valid = 1'b1;
    for (int b = 0; b < NBYTES; b++) begin
      if (oe_ab_i[b] == oe_ba_i[b]) valid = 1'b0;
      if (oe_ab_i[b] != oe_ab_i[0]) valid = 1'b0;
    end
  end

  assign adv_o = run_i & valid;

  always_comb begin
    unique case (op_i[1:0])
      2'b00:   mode_o = M_TOGGLE;
      2'b01:   mode_o = M_PRPG36;
      2'b10:   mode_o = M_PSA36;
      default: mode_o = op_i[2] ? M_PSA_CNT : M_PSA_PRPG;
    endcase
  end
endmodule

// File: rtl/rt_lfsr_step.sv
module rt_lfsr_step #(
  parameter int W   = 18,
  parameter int TAP = 11
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] next_o
);
  // Fibonacci shift-left, feedback taps at W and TAP; data_i folds in a signature
  assign next_o = {state_i[W-2:0], state_i[W-1] ^ state_i[TAP-1]} ^ data_i;
endmodule

// File: rtl/rt_shadow.sv
module rt_shadow #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  AST_SHADOW_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o)); // R4
endmodule

// File: rtl/rt_pattern_engine.sv
module rt_pattern_engine #(
  parameter int          W        = 18,
  parameter int          NBYTES   = 2,
  parameter int          TAP_HALF = 11,
  parameter int          TAP_FULL = 25,
  parameter logic [17:0] OUT_SEED = 18'h2AAAA,
  parameter logic [17:0] IN_SEED  = 18'h00001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [2:0]        op_i,
  input  logic [W-1:0]      mask_i,
  input  logic [NBYTES-1:0] oe_ab_i,
  input  logic [NBYTES-1:0] oe_ba_i,
  input  logic [W-1:0]      pin_i,
  output logic [NBYTES-1:0] out_en_o,
  output logic [W-1:0]      out_cells_o,
  output logic [W-1:0]      in_cells_o,
  output logic [W-1:0]      drv_o
);
  import rt_pkg::*;

  localparam int W2 = 2 * W;

  mode_e          mode;
  logic           adv;
  logic [W-1:0]   out_q, in_q, out_d, in_d;
  logic [W-1:0]   din, misr_half, lfsr_half;
  logic [W2-1:0]  full_data, full_next;

  rt_mode_decode #(.NBYTES(NBYTES)) u_dec (
    .run_i  (run_i),
    .op_i   (op_i),
    .oe_ab_i(oe_ab_i),
    .oe_ba_i(oe_ba_i),
    .mode_o (mode),
    .adv_o  (adv)
  );

  assign din       = pin_i & ~mask_i;
  assign full_data = (mode == M_PSA36) ? {{W{1'b0}}, din} : '0;

  rt_lfsr_step #(.W(W2), .TAP(TAP_FULL)) u_full (
    .state_i({out_q, in_q}),
    .data_i (full_data),
    .next_o (full_next)
  );

  rt_lfsr_step #(.W(W), .TAP(TAP_HALF)) u_misr (
    .state_i(in_q),
    .data_i (din),
    .next_o (misr_half)
  );

  rt_lfsr_step #(.W(W), .TAP(TAP_HALF)) u_prpg (
    .state_i(out_q),
    .data_i ('0),
    .next_o (lfsr_half)
  );

  always_comb begin
    out_d = out_q;
    in_d  = in_q;
    if (adv) begin
      unique case (mode)
        M_TOGGLE:   out_d = ~out_q;
        M_PRPG36,
        M_PSA36:    {out_d, in_d} = full_next;
        M_PSA_PRPG: begin out_d = lfsr_half;     in_d = misr_half; end
        M_PSA_CNT:  begin out_d = out_q + W'(1); in_d = misr_half; end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= OUT_SEED[W-1:0];
      in_q  <= IN_SEED[W-1:0];
    end else begin
      out_q <= out_d;
      in_q  <= in_d;
    end
  end

  rt_shadow #(.W(W)) u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (adv),
    .d_i   (out_q),
    .q_o   (drv_o)
  );

  // drive enable per byte: exactly one direction selected
  for (genvar b = 0; b < NBYTES; b++) begin : g_oe
    assign out_en_o[b] = oe_ab_i[b] ^ oe_ba_i[b];
  end

  assign out_cells_o = out_q;
  assign in_cells_o  = in_q;

  AST_HOLD_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(out_q) && $stable(in_q)); // R2
  AST_TOGGLE_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode == M_TOGGLE) |=> (out_q == ~$past(out_q)) && $stable(in_q)); // R3
  AST_PRPG_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode == M_PRPG36 && {out_q, in_q} != '0) |=> ({out_q, in_q} != '0)); // R5
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode == M_PSA_CNT) |=> (out_q == $past(out_q) + W'(1))); // R8
endmodule

// File: tb/sim_rt_pattern_engine.sv
module sim_rt_pattern_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [2:0]  op_i = 3'b000;
  logic [17:0] mask_i = '0;
  logic [1:0]  oe_ab_i = 2'b11;
  logic [1:0]  oe_ba_i = 2'b00;
  logic [17:0] pin_i = '0;
  logic [1:0]  out_en_o;
  logic [17:0] out_cells_o, in_cells_o, drv_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [17:0] m_out = 18'h2AAAA;
  logic [17:0] m_in  = 18'h00001;
  logic [17:0] m_drv = '0;

  always #5 clk_i = ~clk_i;

  rt_pattern_engine u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .op_i(op_i),
    .mask_i(mask_i), .oe_ab_i(oe_ab_i), .oe_ba_i(oe_ba_i), .pin_i(pin_i),
    .out_en_o(out_en_o), .out_cells_o(out_cells_o),
    .in_cells_o(in_cells_o), .drv_o(drv_o)
  );

  task automatic chk(string tag, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // one rising/falling pair: apply inputs, advance model, compare
  task automatic tick(string tag, bit run, logic [2:0] op, logic [17:0] msk,
                      logic [1:0] ab, logic [1:0] ba, logic [17:0] pins);
    logic [35:0] s;
    logic [17:0] d;
    bit ok;
    run_i = run; op_i = op; mask_i = msk; oe_ab_i = ab; oe_ba_i = ba; pin_i = pins;
    ok = run && (ab[0] != ba[0]) && (ab[1] != ba[1]) && (ab[0] == ab[1]);
    d = pins & ~msk;
    s = {m_out, m_in};
    if (ok) begin
      if (op[1:0] == 2'b00) m_out = ~m_out;
      else if (op[1:0] == 2'b01) {m_out, m_in} = {s[34:0], s[35] ^ s[24]};
      else if (op[1:0] == 2'b10) {m_out, m_in} = {s[34:0], s[35] ^ s[24]} ^ {18'b0, d};
      else begin
        m_in = {m_in[16:0], m_in[17] ^ m_in[10]} ^ d;
        if (op[2]) m_out = m_out + 18'd1;
        else       m_out = {m_out[16:0], m_out[17] ^ m_out[10]};
      end
    end
    @(posedge clk_i); #1;
    chk(tag, "out_cells", {18'b0, out_cells_o}, {18'b0, m_out});
    chk(tag, "in_cells",  {18'b0, in_cells_o},  {18'b0, m_in});
    if (ok) m_drv = m_out;
    @(negedge clk_i); #1;
    chk(tag, "drv", {18'b0, drv_o}, {18'b0, m_drv});
  endtask

  task automatic t_reset;
    chk("R1", "out_cells", {18'b0, out_cells_o}, {18'b0, 18'h2AAAA});
    chk("R1", "in_cells",  {18'b0, in_cells_o},  {18'b0, 18'h00001});
    chk("R1", "drv",       {18'b0, drv_o},       36'h0);
  endtask

  task automatic t_toggle;
    for (int i = 0; i < 4; i++) tick("R3", 1, 3'b000, '0, 2'b11, 2'b00, 18'h3FFFF ^ 18'(i * 7919));
    for (int i = 0; i < 3; i++) tick("R4", 1, 3'b000, '0, 2'b00, 2'b11, 18'h12345);
  endtask

  task automatic t_prpg36;
    for (int i = 0; i < 40; i++) tick("R5", 1, 3'b001, '0, 2'b11, 2'b00, 18'h3C3C3);
  endtask

  task automatic t_psa36;
    for (int i = 0; i < 30; i++) tick("R6", 1, 3'b010, '0, 2'b11, 2'b00, 18'(i * 40503 + 17));
  endtask

  task automatic t_psa_prpg;
    for (int i = 0; i < 30; i++) tick("R7", 1, 3'b011, '0, 2'b00, 2'b11, 18'(i * 12345 + 3));
  endtask

  task automatic t_psa_cnt;
    for (int i = 0; i < 30; i++) tick("R8", 1, 3'b111, '0, 2'b11, 2'b00, 18'(i * 999 + 5));
  endtask

  task automatic t_mask;
    for (int i = 0; i < 12; i++) tick("R9", 1, 3'b010, 18'h3FFFF, 2'b11, 2'b00, 18'h3FFFF);
    for (int i = 0; i < 12; i++) tick("R9", 1, 3'b011, 18'h2A5A5 ^ 18'(i), 2'b11, 2'b00, 18'h3FFFF);
    for (int i = 0; i < 12; i++) tick("R9", 1, 3'b111, 18'h00001 << i, 2'b00, 2'b11, 18'h3FFFF);
  endtask

  task automatic t_bypass;
    tick("R2", 1, 3'b001, '0, 2'b01, 2'b10, 18'h3FFFF);
    tick("R2", 1, 3'b011, '0, 2'b11, 2'b11, 18'h3FFFF);
    tick("R2", 1, 3'b000, '0, 2'b00, 2'b00, 18'h3FFFF);
    tick("R2", 1, 3'b010, '0, 2'b10, 2'b01, 18'h3FFFF);
    tick("R2", 0, 3'b000, '0, 2'b11, 2'b00, 18'h3FFFF);
    tick("R2", 0, 3'b111, '0, 2'b11, 2'b00, 18'h3FFFF);
  endtask

  task automatic t_opcode_msb;
    for (int i = 0; i < 3; i++) tick("R11", 1, 3'b100, '0, 2'b11, 2'b00, 18'h0F0F0);
    for (int i = 0; i < 10; i++) tick("R11", 1, 3'b101, '0, 2'b11, 2'b00, 18'h0F0F0);
    for (int i = 0; i < 10; i++) tick("R11", 1, 3'b110, 18'h000FF, 2'b11, 2'b00, 18'(i * 3571));
  endtask

  task automatic t_out_en;
    for (int v = 0; v < 16; v++) begin
      oe_ab_i = v[1:0]; oe_ba_i = v[3:2]; op_i = 3'(v); run_i = v[0];
      #1;
      chk("R10", "out_en", {34'b0, out_en_o}, {34'b0, oe_ab_i ^ oe_ba_i});
    end
    run_i = 1'b0;
    @(negedge clk_i); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    t_reset();
    t_toggle();
    t_prpg36();
    t_bypass();
    t_psa36();
    t_psa_prpg();
    t_bypass();
    t_psa_cnt();
    t_mask();
    t_opcode_msb();
    t_out_en();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule